// File: doc/BRIEF.md
# Chained Scatter-Gather List Builder

This block turns a stream of page bus addresses into a scatter-gather descriptor list written into a local descriptor memory. A transfer is described once at start: the byte address of the list, the transfer size in bytes, and the byte offset into the first page. Optionally, a substitute buffer address can stand in for a partial first page, and another for a partial last page. The builder works out how many pages the transfer spans. It then takes one page address per stream beat, and emits one 128-bit descriptor write per cycle on a plain write port. The write port carries an entry index: the byte address of entry `i` is `list base + 16*i`.

Descriptors are laid out in blocks of eight 16-byte entries. The first slot of each block is a link entry that points at the block after it. When a page follows directly on the bus from the previous data entry, it is folded into that entry instead of taking a new slot. When the last page has been taken, a clean-up pass rewrites the final block with its link slot squeezed out and closes the list with a terminator entry. The `done` flag pulses with that terminator write.

The page stream uses valid/ready. The source holds `pg_valid` and `pg_addr` until a cycle in which `pg_ready` is high. `pg_ready` depends only on the builder state, never on `pg_valid`. It is low outside a build, for the one cycle in which each block's link entry is written, and during the clean-up pass. The builder expects exactly one beat per page. A beat whose page is covered by a substitute buffer is still consumed, but its address is not used.

Top module: `sgl_builder`

## Requirements
- R1: Each write carries a 128-bit entry `{address[63:0], length[31:0], flags[31:0]}`, with the address in bits 127:64, so byte 0 in memory is the address MSB. Flag codes are 1 for a data entry, 2 for a link entry and 3 for the terminator. No other flag value is ever written.
- R2: Block `b` gets, at entry index `8*b`, a link entry with address `base + 128*(b+1)`, length 128 and flag 2. This entry is written before any data of that block.
- R3: The length of a data entry is the smaller of the bytes still to move and the page size minus the page offset. The configured offset applies only to page 0; later pages have offset 0. The page count is ceil((offset + size) / page size).
- R4: With the first-page substitute enabled, page 0 uses the substitute address plus the offset. The address on the stream beat for page 0 is ignored.
- R5: With the last-page substitute enabled, the last page uses the substitute address with no offset, unless page 0 is also the last page and the first-page substitute is enabled. The address on the stream beat is ignored.
- R6: A page whose resolved address equals the end address (address plus length) of the most recent data entry is not given a new entry. Instead, that entry is rewritten with its length grown by the page's length.
- R7: At the end, if the current block holds `d` data entries (1 to 7), those entries are rewritten to slots 0 to `d-1` of that block, in order, and slot `d` gets the terminator.
- R8: If the current block holds no data entry, because the last page merged into the previous block's slot 7, the previous block is rewritten instead. Its seven data entries go to slots 0 to 6, and slot 7 gets the terminator. The link entry already written for the empty block stays in memory but is no longer reachable.
- R9: The terminator has address 0 and length 0. `done` is high for exactly the one cycle in which the terminator is on the write port. From that cycle on, `busy` is low.
- R10: `pg_ready` is high only while the builder is accepting pages. Every accepted page produces a write in the next cycle. The stream stalls exactly one cycle per link entry. A `start` pulse while `busy` is high is ignored.
- R11: After reset there are no writes, and `busy`, `pg_ready` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a build; sampled only while idle |
| cfg_base | input | 64 | Byte address of the descriptor list |
| cfg_size | input | SIZE_W | Transfer size in bytes (non-zero) |
| cfg_offs | input | PAGE_LG | Byte offset of the data in the first page |
| cfg_first_sub_en | input | 1 | Use a substitute buffer for page 0 |
| cfg_first_sub_addr | input | 64 | Substitute buffer address for page 0 |
| cfg_last_sub_en | input | 1 | Use a substitute buffer for the last page |
| cfg_last_sub_addr | input | 64 | Substitute buffer address for the last page |
| pg_valid | input | 1 | Page address beat valid |
| pg_ready | output | 1 | Builder accepts a page beat this cycle |
| pg_addr | input | 64 | Bus address of the next page |
| wr_en | output | 1 | Descriptor write strobe |
| wr_idx | output | IDX_W | Entry index within the list |
| wr_data | output | 128 | Descriptor entry |
| busy | output | 1 | A build is in progress |
| done | output | 1 | One-cycle pulse with the terminator write |

## Verification
The bench targets the places where positions shift. One case is a list that ends with exactly seven data entries: a design that mishandles it would write the terminator into the next block. Another is a final page that merges across a block boundary: a design that shifts the empty last block instead of the one before it would leave a link entry at the head of the list and the terminator in the wrong block. Merging is exercised with an offset first page and a short tail. Code that ignores the page-0 offset after merging, or that compares against the wrong end address, produces extra entries or wrong lengths. Substitute buffers are set against stream addresses that differ from them, so that any use of the beat address shows up in the list image. The bench also counts link-entry stalls and sends a stray `start` in the middle of a build, so that an extra bubble or a restart would be caught.

// File: rtl/sgl_pkg.sv
package sgl_pkg;
  localparam int ENT_PER_BLK = 8;
  localparam int BLK_BYTES   = 128;
  localparam int DATA_SLOTS  = ENT_PER_BLK - 1;

  localparam logic [31:0] FLG_DATA  = 32'd1;
  localparam logic [31:0] FLG_CHAIN = 32'd2;
  localparam logic [31:0] FLG_END   = 32'd3;

  typedef struct packed {
    logic [63:0] taddr;
    logic [31:0] len;
    logic [31:0] flags;
  } sgl_ent_t;
endpackage

// File: rtl/sgl_page_calc.sv
module sgl_page_calc #(
  parameter int PAGE_LG = 12,
  parameter int SIZE_W  = 32,
  parameter int PG_W    = 22
) (
  input  logic [63:0]        page_addr,
  input  logic [PG_W-1:0]    pidx,
  input  logic [PG_W-1:0]    npg,
  input  logic [PAGE_LG-1:0] offs,
  input  logic               first_en,
  input  logic [63:0]        first_addr,
  input  logic               last_en,
  input  logic [63:0]        last_addr,
  input  logic [SIZE_W-1:0]  rem,
  output logic [63:0]        ent_addr,
  output logic [SIZE_W-1:0]  ent_len
);
  localparam logic [SIZE_W-1:0] PAGE_BYTES = SIZE_W'(1) << PAGE_LG;

  logic              is_first, is_last;
  logic [SIZE_W-1:0] off_ext, room;

  // page offset only counts on page 0
  assign is_first = (pidx == '0);
  assign is_last  = (pidx == (npg - PG_W'(1)));
  assign off_ext  = is_first ? SIZE_W'(offs) : '0;
  assign room     = PAGE_BYTES - off_ext;
  assign ent_len  = (rem < room) ? rem : room;

  always_comb begin
    if (is_first && first_en)
      ent_addr = first_addr + 64'(offs);
    else if (is_last && last_en)
      ent_addr = last_addr;
    else
      ent_addr = page_addr + 64'(off_ext);
  end
endmodule

// File: rtl/sgl_blk_buf.sv
module sgl_blk_buf #(
  parameter int DEPTH  = 7,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] w_slot,
  input  logic [63:0]       w_addr,
  input  logic [31:0]       w_len,
  input  logic [SLOT_W-1:0] r_slot,
  output logic [63:0]       r_addr,
  output logic [31:0]       r_len
);
  logic [63:0] addr_q [DEPTH];
  logic [31:0] len_q  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[g] <= '0;
        len_q[g]  <= '0;
      end else if (we && (w_slot == SLOT_W'(g))) begin
        addr_q[g] <= w_addr;
        len_q[g]  <= w_len;
      end
    end
  end

  always_comb begin
    r_addr = '0;
    r_len  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (r_slot == SLOT_W'(i)) begin
        r_addr = addr_q[i];
        r_len  = len_q[i];
      end
    end
  end
endmodule

// File: rtl/sgl_builder.sv
module sgl_builder #(
  parameter int PAGE_LG = 12,
  parameter int SIZE_W  = 32,
  parameter int IDX_W   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [63:0]        cfg_base,
  input  logic [SIZE_W-1:0]  cfg_size,
  input  logic [PAGE_LG-1:0] cfg_offs,
  input  logic               cfg_first_sub_en,
  input  logic [63:0]        cfg_first_sub_addr,
  input  logic               cfg_last_sub_en,
  input  logic [63:0]        cfg_last_sub_addr,
  input  logic               pg_valid,
  output logic               pg_ready,
  input  logic [63:0]        pg_addr,
  output logic               wr_en,
  output logic [IDX_W-1:0]   wr_idx,
  output logic [127:0]       wr_data,
  output logic               busy,
  output logic               done
);
  import sgl_pkg::*;

  localparam int SLOT_W = $clog2(ENT_PER_BLK);
  localparam int BLK_W  = IDX_W - SLOT_W;
  localparam int PG_W   = SIZE_W + 2 - PAGE_LG;
  localparam int SUM_W  = SIZE_W + 1;
  localparam logic [SUM_W-1:0] PAGE_M1 = (SUM_W'(1) << PAGE_LG) - SUM_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_CHAIN, S_RUN, S_FIX} state_t;

  state_t              state_q;
  logic [63:0]         base_q, fsub_q, lsub_q, lend_q;
  logic                fsub_en_q, lsub_en_q, has_prev_q;
  logic [PAGE_LG-1:0]  offs_q;
  logic [SIZE_W-1:0]   rem_q;
  logic [PG_W-1:0]     npg_q, pidx_q;
  logic [BLK_W-1:0]    blk_q;
  logic [SLOT_W-1:0]   cnt_q, fix_k_q;

  logic [63:0]         ent_addr, rd_addr;
  logic [SIZE_W-1:0]   ent_len;
  logic [31:0]         ent_len32, rd_len, merged_len;
  logic                merge, last_pg, accept;
  logic [SLOT_W-1:0]   mtgt, mtgt_slot, new_slot, fix_n, rd_slot, bw_slot;
  logic [BLK_W-1:0]    mblk, fix_blk;
  logic                bw_en;
  logic [63:0]         bw_addr;
  logic [31:0]         bw_len;
  logic [SUM_W-1:0]    span;

  sgl_page_calc #(.PAGE_LG(PAGE_LG), .SIZE_W(SIZE_W), .PG_W(PG_W)) u_calc (
    .page_addr (pg_addr),
    .pidx      (pidx_q),
    .npg       (npg_q),
    .offs      (offs_q),
    .first_en  (fsub_en_q),
    .first_addr(fsub_q),
    .last_en   (lsub_en_q),
    .last_addr (lsub_q),
    .rem       (rem_q),
    .ent_addr  (ent_addr),
    .ent_len   (ent_len)
  );

  // merge target: last data entry, which is previous block slot 7 when the
  // current block has none yet
  assign ent_len32  = 32'(ent_len);
  assign accept     = (state_q == S_RUN) && pg_valid;
  assign merge      = has_prev_q && (ent_addr == lend_q);
  assign last_pg    = (pidx_q == (npg_q - PG_W'(1)));
  assign mtgt       = (cnt_q == '0) ? SLOT_W'(DATA_SLOTS - 1) : cnt_q - SLOT_W'(1);
  assign mblk       = (cnt_q == '0) ? blk_q - BLK_W'(1) : blk_q;
  assign mtgt_slot  = mtgt + SLOT_W'(1);
  assign new_slot   = cnt_q + SLOT_W'(1);
  assign fix_n      = (cnt_q == '0) ? SLOT_W'(DATA_SLOTS) : cnt_q;
  assign fix_blk    = mblk;
  assign rd_slot    = (state_q == S_FIX) ? fix_k_q : mtgt;
  assign merged_len = rd_len + ent_len32;
  assign span       = SUM_W'(cfg_size) + SUM_W'(cfg_offs) + PAGE_M1;

  assign bw_en   = accept;
  assign bw_slot = merge ? mtgt : cnt_q;
  assign bw_addr = merge ? rd_addr : ent_addr;
  assign bw_len  = merge ? merged_len : ent_len32;

  sgl_blk_buf #(.DEPTH(DATA_SLOTS), .SLOT_W(SLOT_W)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bw_en),
    .w_slot(bw_slot),
    .w_addr(bw_addr),
    .w_len (bw_len),
    .r_slot(rd_slot),
    .r_addr(rd_addr),
    .r_len (rd_len)
  );

  assign pg_ready = (state_q == S_RUN);
  assign busy     = (state_q != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      base_q     <= '0;
      fsub_q     <= '0;
      lsub_q     <= '0;
      lend_q     <= '0;
      fsub_en_q  <= 1'b0;
      lsub_en_q  <= 1'b0;
      has_prev_q <= 1'b0;
      offs_q     <= '0;
      rem_q      <= '0;
      npg_q      <= '0;
      pidx_q     <= '0;
      blk_q      <= '0;
      cnt_q      <= '0;
      fix_k_q    <= '0;
      wr_en      <= 1'b0;
      wr_idx     <= '0;
      wr_data    <= '0;
      done       <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            base_q     <= cfg_base;
            fsub_q     <= cfg_first_sub_addr;
            lsub_q     <= cfg_last_sub_addr;
            fsub_en_q  <= cfg_first_sub_en;
            lsub_en_q  <= cfg_last_sub_en;
            offs_q     <= cfg_offs;
            rem_q      <= cfg_size;
            npg_q      <= PG_W'(span >> PAGE_LG);
            pidx_q     <= '0;
            blk_q      <= '0;
            cnt_q      <= '0;
            fix_k_q    <= '0;
            has_prev_q <= 1'b0;
            lend_q     <= '0;
            state_q    <= S_CHAIN;
          end
        end
        S_CHAIN: begin
          wr_en   <= 1'b1;
          wr_idx  <= {blk_q, SLOT_W'(0)};
          wr_data <= sgl_ent_t'{taddr: base_q + ((64'(blk_q) + 64'd1) << 7),
                                len:   32'(BLK_BYTES),
                                flags: FLG_CHAIN};
          state_q <= S_RUN;
        end
        S_RUN: begin
          if (pg_valid) begin
            wr_en      <= 1'b1;
            has_prev_q <= 1'b1;
            rem_q      <= rem_q - ent_len;
            pidx_q     <= pidx_q + PG_W'(1);
            if (merge) begin
              wr_idx  <= {mblk, mtgt_slot};
              wr_data <= sgl_ent_t'{taddr: rd_addr, len: merged_len, flags: FLG_DATA};
              lend_q  <= lend_q + 64'(ent_len);
            end else begin
              wr_idx  <= {blk_q, new_slot};
              wr_data <= sgl_ent_t'{taddr: ent_addr, len: ent_len32, flags: FLG_DATA};
              lend_q  <= ent_addr + 64'(ent_len);
              cnt_q   <= new_slot;
            end
            if (last_pg) begin
              fix_k_q <= '0;
              state_q <= S_FIX;
            end else if (!merge && (cnt_q == SLOT_W'(DATA_SLOTS - 1))) begin
              blk_q   <= blk_q + BLK_W'(1);
              cnt_q   <= '0;
              state_q <= S_CHAIN;
            end
          end
        end
        S_FIX: begin
          wr_en <= 1'b1;
          if (fix_k_q < fix_n) begin
            wr_idx  <= {fix_blk, fix_k_q};
            wr_data <= sgl_ent_t'{taddr: rd_addr, len: rd_len, flags: FLG_DATA};
            fix_k_q <= fix_k_q + SLOT_W'(1);
          end else begin
            wr_idx  <= {fix_blk, fix_n};
            wr_data <= sgl_ent_t'{taddr: 64'd0, len: 32'd0, flags: FLG_END};
            done    <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgl_builder_chk.sv
module sgl_builder_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             pg_valid,
  input logic             pg_ready,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic [127:0]     wr_data,
  input logic             done
);
  logic [31:0] flg, len;
  assign flg = wr_data[31:0];
  assign len = wr_data[63:32];

  assert_flags_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (flg == 32'd1 || flg == 32'd2 || flg == 32'd3));

  assert_chain_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && flg == 32'd2) |-> (len == 32'd128 && wr_idx[2:0] == 3'd0));

  assert_data_len_nz_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && flg == 32'd1) |-> (len != 32'd0));

  assert_end_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_en && flg == 32'd3 && wr_data[127:32] == 96'd0 && !busy));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ready_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pg_ready);

  assert_accept_writes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_valid && pg_ready) |=> (wr_en && wr_data[31:0] == 32'd1));
endmodule

bind sgl_builder sgl_builder_chk #(.IDX_W(IDX_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .pg_valid(pg_valid),
  .pg_ready(pg_ready),
  .wr_en   (wr_en),
  .wr_idx  (wr_idx),
  .wr_data (wr_data),
  .done    (done)
);

// File: tb/tb_sgl_builder.sv
module tb_sgl_builder;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_LG = 12;
  localparam int SIZE_W  = 32;
  localparam int IDX_W   = 10;
  localparam logic [63:0] BASE = 64'h1000_0000;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [63:0] cfg_base = BASE, cfg_fa = '0, cfg_la = '0, pg_addr = '0;
  logic [SIZE_W-1:0] cfg_size = '0;
  logic [PAGE_LG-1:0] cfg_offs = '0;
  logic cfg_fen = 1'b0, cfg_len = 1'b0, pg_valid = 1'b0;
  logic pg_ready, wr_en, busy, done;
  logic [IDX_W-1:0] wr_idx;
  logic [127:0] wr_data;

  sgl_builder #(.PAGE_LG(PAGE_LG), .SIZE_W(SIZE_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
    .cfg_size(cfg_size), .cfg_offs(cfg_offs),
    .cfg_first_sub_en(cfg_fen), .cfg_first_sub_addr(cfg_fa),
    .cfg_last_sub_en(cfg_len), .cfg_last_sub_addr(cfg_la),
    .pg_valid(pg_valid), .pg_ready(pg_ready), .pg_addr(pg_addr),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .busy(busy), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, npg = 0;
  logic [127:0] mem [64];
  logic [127:0] em [64];
  logic [63:0] pa [16];
  bit done_seen = 1'b0;

  always @(negedge clk) begin
    if (wr_en && wr_idx < IDX_W'(64)) mem[wr_idx[5:0]] = wr_data;
    if (done) done_seen = 1'b1;
  end

  function automatic logic [127:0] ent(input logic [63:0] a, input logic [31:0] l,
                                       input logic [31:0] f);
    return {a, l, f};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // list image computed from the requirements
  task automatic model();
    longint unsigned rem = cfg_size, lend = 0;
    int b = 0, c = 0, fb, fn;
    bit have = 0;
    for (int i = 0; i < 64; i++) em[i] = '1;
    em[0] = ent(BASE + 128, 128, 2);
    for (int p = 0; p < npg; p++) begin
      longint unsigned off, ea, room, el;
      off = (p == 0) ? longint'(cfg_offs) : 0;
      if (p == 0 && cfg_fen) ea = cfg_fa + longint'(cfg_offs);
      else if (p == npg - 1 && cfg_len) ea = cfg_la;
      else ea = pa[p] + off;
      room = 4096 - off;
      el = (rem < room) ? rem : room;
      if (have && ea == lend) begin
        int s = (c == 0) ? (b - 1) * 8 + 7 : b * 8 + c;
        em[s][63:32] = em[s][63:32] + 32'(el);
        lend = lend + el;
      end else begin
        c++;
        em[b*8+c] = ent(ea, 32'(el), 1);
        lend = ea + el;
      end
      have = 1;
      rem = rem - el;
      if (p == npg - 1) break;
      if (c == 7) begin
        b++; c = 0;
        em[b*8] = ent(BASE + 64'(128 * (b + 1)), 128, 2);
      end
    end
    fb = (c == 0) ? b - 1 : b;
    fn = (c == 0) ? 7 : c;
    for (int k = 0; k < fn; k++) em[fb*8+k] = em[fb*8+k+1];
    em[fb*8+fn] = ent(0, 0, 3);
  endtask

  task automatic run(input string tag, input bit poke, output int stalls);
    int mism = 0, first = 0;
    logic [SIZE_W-1:0] keep;
    stalls = 0;
    npg = (int'(cfg_offs) + int'(cfg_size) + 4095) / 4096;
    for (int i = 0; i < 64; i++) mem[i] = '1;
    done_seen = 1'b0;
    model();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < npg; i++) begin
      pg_valid = 1'b1;
      pg_addr = pa[i];
      keep = cfg_size;
      if (poke && i == 2) begin start = 1'b1; cfg_size = 32'd77; end
      while (!pg_ready) begin stalls++; @(negedge clk); end
      @(negedge clk);
      start = 1'b0; cfg_size = keep;
    end
    pg_valid = 1'b0;
    for (int t = 0; t < 3000 && !done_seen; t++) begin @(negedge clk); #1; end
    chk(done_seen, {"R9 done pulse ", tag}, 128'(done_seen), 128'd1);
    @(negedge clk); #1;
    chk(!busy && !pg_ready, {"R9 idle after done ", tag}, 128'({busy, pg_ready}), 128'd0);
    for (int i = 63; i >= 0; i--) if (mem[i] !== em[i]) begin mism++; first = i; end
    chk(mism == 0, {"R7 list image ", tag}, mem[first], em[first]);
  endtask

  task automatic set_cfg(input int size, input int offs, input bit fen,
                         input logic [63:0] fa, input bit len_, input logic [63:0] la);
    cfg_size = 32'(size); cfg_offs = 12'(offs);
    cfg_fen = fen; cfg_fa = fa; cfg_len = len_; cfg_la = la;
  endtask

  task automatic spread_pages();
    for (int i = 0; i < 16; i++) pa[i] = 64'h8000_0000 + 64'(i) * 64'h1_0000;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy, "R11 busy", 128'(busy), 0);
    chk(!pg_ready, "R11 ready", 128'(pg_ready), 0);
    chk(!wr_en, "R11 wr_en", 128'(wr_en), 0);
    chk(!done, "R11 done", 128'(done), 0);
  endtask

  task automatic t_single();
    int st;
    spread_pages();
    set_cfg(200, 100, 0, 0, 0, 0);
    run("single", 0, st);
    chk(mem[0] == ent(64'h8000_0064, 200, 1), "R3 R1 single entry", mem[0],
        ent(64'h8000_0064, 200, 1));
    chk(mem[1] == ent(0, 0, 3), "R9 terminator", mem[1], ent(0, 0, 3));
    chk(st == 1, "R10 stalls single", 128'(st), 1);
  endtask

  task automatic t_tail();
    int st;
    spread_pages();
    set_cfg(3 * 4096 - 10, 0, 0, 0, 0, 0);
    run("tail", 0, st);
    chk(mem[2] == ent(pa[2], 4086, 1), "R3 short tail", mem[2], ent(pa[2], 4086, 1));
  endtask

  task automatic t_merge();
    int st;
    for (int i = 0; i < 16; i++) pa[i] = 64'h4000_0000 + 64'(i) * 4096;
    set_cfg(4 * 4096, 16, 0, 0, 0, 0);
    run("merge", 0, st);
    chk(mem[0] == ent(64'h4000_0010, 16384, 1), "R6 merged entry", mem[0],
        ent(64'h4000_0010, 16384, 1));
    chk(mem[1] == ent(0, 0, 3), "R6 R7 end after merge", mem[1], ent(0, 0, 3));
  endtask

  task automatic t_subs();
    int st;
    spread_pages();
    set_cfg(8192, 512, 1, 64'h9000_0000, 1, 64'hA000_0000);
    run("subs", 0, st);
    chk(mem[0] == ent(64'h9000_0200, 3584, 1), "R4 first substitute", mem[0],
        ent(64'h9000_0200, 3584, 1));
    chk(mem[1] == ent(pa[1], 4096, 1), "R3 middle page", mem[1], ent(pa[1], 4096, 1));
    chk(mem[2] == ent(64'hA000_0000, 512, 1), "R5 last substitute", mem[2],
        ent(64'hA000_0000, 512, 1));
  endtask

  task automatic t_two_blocks();
    int st;
    spread_pages();
    set_cfg(10 * 4096, 0, 0, 0, 0, 0);
    run("two blocks", 1, st);
    chk(mem[0] == ent(BASE + 128, 128, 2), "R2 link entry", mem[0], ent(BASE + 128, 128, 2));
    chk(mem[8] == ent(pa[7], 4096, 1), "R7 shifted head", mem[8], ent(pa[7], 4096, 1));
    chk(mem[11] == ent(0, 0, 3), "R7 end slot", mem[11], ent(0, 0, 3));
    chk(st == 2, "R10 one stall per link", 128'(st), 2);
  endtask

  task automatic t_seven();
    int st;
    spread_pages();
    set_cfg(7 * 4096, 0, 0, 0, 0, 0);
    run("seven", 0, st);
    chk(mem[6] == ent(pa[6], 4096, 1), "R7 full block slot6", mem[6], ent(pa[6], 4096, 1));
    chk(mem[7] == ent(0, 0, 3), "R7 full block end", mem[7], ent(0, 0, 3));
  endtask

  task automatic t_cross_merge();
    int st;
    spread_pages();
    pa[7] = pa[6] + 4096;
    set_cfg(8 * 4096, 0, 0, 0, 0, 0);
    run("cross merge", 0, st);
    chk(mem[6] == ent(pa[6], 8192, 1), "R8 merged into prev block", mem[6],
        ent(pa[6], 8192, 1));
    chk(mem[7] == ent(0, 0, 3), "R8 end in prev block", mem[7], ent(0, 0, 3));
    chk(mem[8] == ent(BASE + 256, 128, 2), "R2 R8 stale link kept", mem[8],
        ent(BASE + 256, 128, 2));
    chk(st == 2, "R10 stalls cross", 128'(st), 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_single();
    t_tail();
    t_merge();
    t_subs();
    t_two_blocks();
    t_seven();
    t_cross_merge();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule